// File: doc/BRIEF.md
# TLB Translation Request Coalescer

This block stands between a set of address-translation requesters and a TLB. Requests that carry the same time-window index and touch the same 4 KiB virtual page are gathered into one group, and each group becomes a single probe to the TLB. When the TLB returns the physical page for a probe, the block hands a completed translation back to every requester that was merged into that group. Each completion keeps that requester's own page offset.

A request carries an issue cycle. Its window index is that cycle divided by `WINDOW`, and only requests with equal indices can share a group. A group holds at most `MEMBERS` requesters. Groups wait in a pending store of `GROUPS` slots and are issued to the TLB oldest first, up to `PROBES` per cycle. The TLB accepts or refuses the whole issued bundle with one ready signal. A refused bundle stays at the head and is offered again before anything newer. A slot whose probe has been answered and fully delivered is placed on a cleanup queue and is freed on a later cycle. Three counters report requests taken, probes accepted and request-weighted waiting cycles.

All data channels use valid/ready. A transfer happens on a clock edge where both are high. `req_ready` drops only when no slot is free. `resp_ready` drops while a previous answer is still being delivered. A valid output holds its payload until its ready is seen. Issue cycles are expected to be non-decreasing from request to request.

Top module: `tlb_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `probe_valid` and `done_valid` are 0, and all three counters read 0.
- R2: With `coalesce_off` low, an accepted request joins a waiting group that has the same window index (`req_cycle / WINDOW`) and the same virtual page (`req_addr[ADDR_W-1:12]`), as long as the group holds fewer than `MEMBERS` (4) requesters. A fifth such request opens a new group.
- R3: Requests that differ in window index or in virtual page are never placed in the same group, so each gets its own probe.
- R4: With `coalesce_off` high, every accepted request opens its own group and receives exactly one completion.
- R5: Lane k of `probe_valid` is high only if lanes below k are high. Lane 0 carries the oldest waiting group, and groups are issued in the order they were created, at most `PROBES` per cycle.
- R6: While `probe_valid` is nonzero and `probe_ready` is low, the offered probes stay unchanged. They are the first ones issued once `probe_ready` rises.
- R7: An accepted response whose page matches an outstanding probe produces one completion per merged requester, in the order they joined. Each completion carries that requester's id and `{resp_ppn, own offset}` as `done_paddr`, and the payload is held while `done_ready` is low.
- R8: An accepted response whose page matches no outstanding probe is consumed and produces no completion.
- R9: When all `GROUPS` slots are in use, `req_ready` is 0. A slot whose last completion is taken at edge E is not free after E; it is free after edge E+1.
- R10: `stat_req` counts accepted requests. `stat_probe` counts probes accepted by the TLB. `stat_wait` adds, at every edge, the number of requesters held in groups that have not yet been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coalesce_off | input | 1 | When high, every request gets its own probe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when high with valid |
| req_addr | input | ADDR_W | Virtual address of the request |
| req_id | input | ID_W | Requester tag returned with the completion |
| req_cycle | input | CYC_W | Issue cycle of the request |
| probe_valid | output | PROBES | Per-lane probe valid (prefix mask) |
| probe_ready | input | 1 | TLB takes every valid lane on this edge |
| probe_vpn | output | PROBES*VPN_W | Virtual page per lane, lane 0 in the low bits |
| resp_valid | input | 1 | TLB answer valid |
| resp_ready | output | 1 | Answer accepted on this edge when high with valid |
| resp_vpn | input | VPN_W | Virtual page being answered |
| resp_ppn | input | VPN_W | Physical page for that virtual page |
| done_valid | output | 1 | Completion valid |
| done_ready | input | 1 | Completion consumer ready |
| done_id | output | ID_W | Tag of the requester being completed |
| done_paddr | output | ADDR_W | Physical address: page from the TLB, offset from the request |
| stat_req | output | CNT_W | Requests accepted |
| stat_probe | output | CNT_W | Probes accepted by the TLB |
| stat_wait | output | CNT_W | Request-weighted cycles spent before issue |

## Verification
The bench targets the edges of grouping. A fourth same-page request must still merge and a fifth must not, so a design with an off-by-one member limit hands five completions to one answer. Requests on the same page but in the next window must stay apart, or a design keying only on the page would merge them. It holds a refused bundle for several cycles and checks that the lanes do not advance, which catches a design that drops or reorders a retried probe. It checks the weighted waiting count cycle by cycle, which exposes unweighted counting. It also confirms that a drained slot comes back only one edge after its last completion and that an unmatched answer yields nothing, so a design that frees early or completes a stray group fails.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  typedef enum logic [2:0] {
    SL_FREE,   // slot unused
    SL_WAIT,   // group gathering, probe not yet taken by the TLB
    SL_OUT,    // probe outstanding
    SL_FILL,   // answer received, members being completed
    SL_CLEAN   // queued for release
  } slot_st_e;
endpackage

// File: rtl/tlbc_pick.sv
module tlbc_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlbc_fifo.sv
module tlbc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  parameter int POPS  = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(POPS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           push_data,
  input  logic [NW-1:0]          pop_n,
  output logic [CW-1:0]          count,
  output logic [POPS-1:0][W-1:0] peek
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      rd_ptr <= rd_ptr + PW'(pop_n);
      count  <= count + CW'(push) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_comb begin
    for (int k = 0; k < POPS; k++) peek[k] = mem[rd_ptr + PW'(k)];
  end

  // R5: never release more entries than are held
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);
  // R9: never accept an entry into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)) || (pop_n != '0));
endmodule

// File: rtl/tlb_coalescer.sv
module tlb_coalescer
  import tlbc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int ID_W    = 4,
  parameter int CYC_W   = 16,
  parameter int WINDOW  = 1,
  parameter int PROBES  = 2,
  parameter int GROUPS  = 8,
  parameter int MEMBERS = 4,
  parameter int CNT_W   = 32,
  localparam int VPN_W = ADDR_W - PAGE_W,
  localparam int GI_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int MI_W  = (MEMBERS > 1) ? $clog2(MEMBERS) : 1,
  localparam int MC_W  = $clog2(MEMBERS + 1),
  localparam int PC_W  = $clog2(PROBES + 1),
  localparam int FC_W  = $clog2(GROUPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      coalesce_off,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [ID_W-1:0]           req_id,
  input  logic [CYC_W-1:0]          req_cycle,
  output logic [PROBES-1:0]         probe_valid,
  input  logic                      probe_ready,
  output logic [PROBES*VPN_W-1:0]   probe_vpn,
  input  logic                      resp_valid,
  output logic                      resp_ready,
  input  logic [VPN_W-1:0]          resp_vpn,
  input  logic [VPN_W-1:0]          resp_ppn,
  output logic                      done_valid,
  input  logic                      done_ready,
  output logic [ID_W-1:0]           done_id,
  output logic [ADDR_W-1:0]         done_paddr,
  output logic [CNT_W-1:0]          stat_req,
  output logic [CNT_W-1:0]          stat_probe,
  output logic [CNT_W-1:0]          stat_wait
);
  // slot storage
  slot_st_e          st    [GROUPS];
  logic [VPN_W-1:0]  s_vpn [GROUPS];
  logic [CYC_W-1:0]  s_key [GROUPS];
  logic [MC_W-1:0]   s_cnt [GROUPS];
  logic [ID_W-1:0]   s_id  [GROUPS][MEMBERS];
  logic [PAGE_W-1:0] s_off [GROUPS][MEMBERS];

  // completion state
  logic              fill_on;
  logic [GI_W-1:0]   fill_slot;
  logic [MI_W-1:0]   fill_pos;
  logic [VPN_W-1:0]  fill_ppn;

  logic [VPN_W-1:0]  in_vpn;
  logic [CYC_W-1:0]  in_key;
  logic [GROUPS-1:0] free_vec, merge_vec, match_vec;
  logic              free_found, merge_found, match_found;
  logic [GI_W-1:0]   free_idx, merge_idx, match_idx;

  assign in_vpn = req_addr[ADDR_W-1:PAGE_W];
  assign in_key = req_cycle / CYC_W'(WINDOW);

  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      free_vec[g]  = (st[g] == SL_FREE);
      merge_vec[g] = (st[g] == SL_WAIT) && !coalesce_off && (s_vpn[g] == in_vpn)
                     && (s_key[g] == in_key) && (s_cnt[g] < MC_W'(MEMBERS));
      match_vec[g] = (st[g] == SL_OUT) && (s_vpn[g] == resp_vpn);
    end
  end

  tlbc_pick #(.N(GROUPS)) u_pick_free  (.req(free_vec),  .found(free_found),  .idx(free_idx));
  tlbc_pick #(.N(GROUPS)) u_pick_merge (.req(merge_vec), .found(merge_found), .idx(merge_idx));
  tlbc_pick #(.N(GROUPS)) u_pick_match (.req(match_vec), .found(match_found), .idx(match_idx));

  logic req_fire, do_merge, do_alloc;
  assign req_ready = free_found;
  assign req_fire  = req_valid && req_ready;
  assign do_merge  = req_fire && merge_found;
  assign do_alloc  = req_fire && !merge_found;

  // issue queue: creation order, doubles as the retry queue
  logic [FC_W-1:0]              iss_count;
  logic [PROBES-1:0][GI_W-1:0]  iss_peek;
  logic [PC_W-1:0]              iss_n, iss_pop;
  logic                         probe_fire;

  assign iss_n      = (iss_count > FC_W'(PROBES)) ? PC_W'(PROBES) : PC_W'(iss_count);
  assign probe_fire = probe_ready && (iss_count != '0);
  assign iss_pop    = probe_fire ? iss_n : '0;

  tlbc_fifo #(.DEPTH(GROUPS), .W(GI_W), .POPS(PROBES)) u_issue_q (
    .clk(clk), .rst_n(rst_n), .push(do_alloc), .push_data(free_idx),
    .pop_n(iss_pop), .count(iss_count), .peek(iss_peek));

  for (genvar k = 0; k < PROBES; k++) begin : g_lane
    assign probe_valid[k] = (iss_count > FC_W'(k));
    assign probe_vpn[k*VPN_W +: VPN_W] = s_vpn[iss_peek[k]];
  end

  // response and fan-out
  logic resp_fire, resp_hit, done_fire, done_last;
  assign resp_ready = !fill_on;
  assign resp_fire  = resp_valid && resp_ready;
  assign resp_hit   = resp_fire && match_found;
  assign done_valid = fill_on;
  assign done_id    = s_id[fill_slot][fill_pos];
  assign done_paddr = {fill_ppn, s_off[fill_slot][fill_pos]};
  assign done_fire  = done_valid && done_ready;
  assign done_last  = done_fire && ((MC_W'(fill_pos) + MC_W'(1)) == s_cnt[fill_slot]);

  // cleanup queue: release happens on a later edge than the last completion
  logic [GI_W:0]          cl_count;
  logic [0:0][GI_W-1:0]   cl_peek;
  logic                   cl_pop;
  assign cl_pop = (cl_count != '0);

  tlbc_fifo #(.DEPTH(GROUPS), .W(GI_W), .POPS(1)) u_clean_q (
    .clk(clk), .rst_n(rst_n), .push(done_last), .push_data(fill_slot),
    .pop_n(cl_pop), .count(cl_count), .peek(cl_peek));

  logic [CNT_W-1:0] wait_sum;
  always_comb begin
    wait_sum = '0;
    for (int g = 0; g < GROUPS; g++)
      if (st[g] == SL_WAIT) wait_sum = wait_sum + CNT_W'(s_cnt[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++) begin
        st[g]    <= SL_FREE;
        s_cnt[g] <= '0;
      end
      fill_on    <= 1'b0;
      fill_slot  <= '0;
      fill_pos   <= '0;
      fill_ppn   <= '0;
      stat_req   <= '0;
      stat_probe <= '0;
      stat_wait  <= '0;
    end else begin
      if (do_alloc) begin
        st[free_idx]    <= SL_WAIT;
        s_cnt[free_idx] <= MC_W'(1);
      end
      if (do_merge) s_cnt[merge_idx] <= s_cnt[merge_idx] + MC_W'(1);
      for (int k = 0; k < PROBES; k++)
        if (probe_fire && (FC_W'(k) < iss_count)) st[iss_peek[k]] <= SL_OUT;
      if (resp_hit) begin
        st[match_idx] <= SL_FILL;
        fill_on       <= 1'b1;
        fill_slot     <= match_idx;
        fill_pos      <= '0;
        fill_ppn      <= resp_ppn;
      end else if (done_fire) begin
        if (done_last) begin
          fill_on       <= 1'b0;
          st[fill_slot] <= SL_CLEAN;
        end else begin
          fill_pos <= fill_pos + MI_W'(1);
        end
      end
      if (cl_pop) st[cl_peek[0]] <= SL_FREE;
      stat_req   <= stat_req + CNT_W'(req_fire);
      stat_probe <= stat_probe + CNT_W'(iss_pop);
      stat_wait  <= stat_wait + wait_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      s_vpn[free_idx]    <= in_vpn;
      s_key[free_idx]    <= in_key;
      s_id[free_idx][0]  <= req_id;
      s_off[free_idx][0] <= req_addr[PAGE_W-1:0];
    end
    if (do_merge) begin
      s_id[merge_idx][MI_W'(s_cnt[merge_idx])]  <= req_id;
      s_off[merge_idx][MI_W'(s_cnt[merge_idx])] <= req_addr[PAGE_W-1:0];
    end
  end

  // R6: a refused bundle is offered again unchanged
  a_r6_probe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid[0] && !probe_ready |=> probe_valid[0] && $stable(probe_vpn[VPN_W-1:0]));
  // R7: a completion holds its payload until taken
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_id) && $stable(done_paddr));
  // R10: each accepted request is counted once
  a_r10_req_count: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> stat_req == $past(stat_req) + CNT_W'(1));
endmodule

// File: tb/tlb_coalescer_bench.sv
module tlb_coalescer_bench;
  localparam int ADDR_W = 32, PAGE_W = 12, ID_W = 4, CYC_W = 16;
  localparam int PROBES = 2, GROUPS = 8, VPN_W = ADDR_W - PAGE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coalesce_off = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ID_W-1:0] req_id = '0;
  logic [CYC_W-1:0] req_cycle = '0;
  logic [PROBES-1:0] probe_valid;
  logic probe_ready = 1'b0;
  logic [PROBES*VPN_W-1:0] probe_vpn;
  logic resp_valid = 1'b0, resp_ready;
  logic [VPN_W-1:0] resp_vpn = '0, resp_ppn = '0;
  logic done_valid, done_ready = 1'b1;
  logic [ID_W-1:0] done_id;
  logic [ADDR_W-1:0] done_paddr;
  logic [31:0] stat_req, stat_probe, stat_wait;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  tlb_coalescer #(.WINDOW(2)) u_tlb_coalescer (
    .clk(clk), .rst_n(rst_n), .coalesce_off(coalesce_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_id(req_id), .req_cycle(req_cycle),
    .probe_valid(probe_valid), .probe_ready(probe_ready), .probe_vpn(probe_vpn),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_vpn(resp_vpn),
    .resp_ppn(resp_ppn), .done_valid(done_valid), .done_ready(done_ready),
    .done_id(done_id), .done_paddr(done_paddr),
    .stat_req(stat_req), .stat_probe(stat_probe), .stat_wait(stat_wait));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic send(input logic [ID_W-1:0] id, input logic [VPN_W-1:0] vpn,
                      input logic [PAGE_W-1:0] off, input int cyc);
    req_valid = 1'b1; req_id = id; req_addr = {vpn, off}; req_cycle = CYC_W'(cyc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [VPN_W-1:0] vpn, input logic [VPN_W-1:0] ppn);
    resp_valid = 1'b1; resp_vpn = vpn; resp_ppn = ppn;
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  task automatic expect_done(input string req, input logic [ID_W-1:0] id,
                             input logic [ADDR_W-1:0] pa);
    chk(done_valid == 1'b1, req, 64'(done_valid), 64'd1);
    chk(done_id == id, req, 64'(done_id), 64'(id));
    chk(done_paddr == pa, req, 64'(done_paddr), 64'(pa));
    @(negedge clk);
  endtask

  localparam logic [VPN_W-1:0] PG_A = 20'h12345, PG_B = 20'h0ABCD, PG_X = 20'h00777;
  localparam logic [VPN_W-1:0] PP_1 = 20'hFEDCB, PP_2 = 20'h55AA5, PP_3 = 20'h13579;

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(probe_valid == '0, "R1 probe_valid", 64'(probe_valid), 64'd0);
    chk(done_valid == 1'b0, "R1 done_valid", 64'(done_valid), 64'd0);
    chk(stat_req == 0 && stat_probe == 0 && stat_wait == 0, "R1 counters",
        64'(stat_req + stat_probe + stat_wait), 64'd0);

    // R2 / R3: window 2 -> cycles 4,5 share key 2, cycle 6 is key 3
    send(4'd1, PG_A, 12'h010, 4);
    send(4'd2, PG_A, 12'h020, 5);
    send(4'd3, PG_A, 12'h030, 4);
    send(4'd4, PG_A, 12'h040, 5);
    send(4'd5, PG_A, 12'h050, 5);   // fifth: new group
    send(4'd6, PG_B, 12'h060, 5);   // other page
    send(4'd7, PG_A, 12'h070, 6);   // next window
    chk(stat_req == 7, "R10 stat_req", 64'(stat_req), 64'd7);
    chk(stat_wait == 21, "R10 stat_wait weighted", 64'(stat_wait), 64'd21);
    chk(probe_valid == 2'b11, "R5 two lanes", 64'(probe_valid), 64'd3);
    chk(probe_vpn[VPN_W-1:0] == PG_A, "R5 lane0", 64'(probe_vpn[VPN_W-1:0]), 64'(PG_A));
    // R6 hold while refused
    repeat (3) @(negedge clk);
    chk(probe_vpn == {PG_A, PG_A}, "R6 held bundle", 64'(probe_vpn), 64'({PG_A, PG_A}));
    chk(stat_wait == 42, "R10 stat_wait hold", 64'(stat_wait), 64'd42);
    probe_ready = 1'b1;
    @(negedge clk);
    chk(stat_probe == 2, "R10 stat_probe", 64'(stat_probe), 64'd2);
    chk(probe_vpn == {PG_A, PG_B}, "R5 R3 next lanes", 64'(probe_vpn), 64'({PG_A, PG_B}));
    @(negedge clk);
    probe_ready = 1'b0;
    chk(probe_valid == '0, "R5 drained", 64'(probe_valid), 64'd0);
    chk(stat_probe == 4, "R10 stat_probe all", 64'(stat_probe), 64'd4);
    chk(stat_wait == 51, "R10 stat_wait final", 64'(stat_wait), 64'd51);

    // R8 unmatched answer
    respond(PG_X, PP_3);
    chk(done_valid == 1'b0, "R8 no completion", 64'(done_valid), 64'd0);
    @(negedge clk);
    chk(done_valid == 1'b0, "R8 still none", 64'(done_valid), 64'd0);

    // R7 fan-out of the four-member group, with a stall
    respond(PG_A, PP_1);
    done_ready = 1'b0;
    @(negedge clk);
    done_ready = 1'b1;
    expect_done("R7 m1", 4'd1, {PP_1, 12'h010});
    expect_done("R7 m2", 4'd2, {PP_1, 12'h020});
    expect_done("R7 m3", 4'd3, {PP_1, 12'h030});
    expect_done("R7 m4", 4'd4, {PP_1, 12'h040});
    chk(done_valid == 1'b0, "R2 group of four ends", 64'(done_valid), 64'd0);
    respond(PG_A, PP_2);
    expect_done("R2 fifth alone", 4'd5, {PP_2, 12'h050});
    chk(done_valid == 1'b0, "R2 fifth single", 64'(done_valid), 64'd0);
    respond(PG_A, PP_3);
    expect_done("R3 next window", 4'd7, {PP_3, 12'h070});
    respond(PG_B, PP_1);
    expect_done("R3 other page", 4'd6, {PP_1, 12'h060});
    repeat (3) @(negedge clk);

    // R4 / R9: coalescing off fills every slot
    coalesce_off = 1'b1;
    for (int i = 0; i < GROUPS; i++) send(ID_W'(8 + i), PG_A, 12'(i * 16), 8);
    chk(req_ready == 1'b0, "R9 full", 64'(req_ready), 64'd0);
    chk(stat_req == 15, "R10 stat_req off", 64'(stat_req), 64'd15);
    probe_ready = 1'b1;
    repeat (4) @(negedge clk);
    probe_ready = 1'b0;
    chk(stat_probe == 12, "R4 one probe each", 64'(stat_probe), 64'd12);
    respond(PG_A, PP_2);
    chk(req_ready == 1'b0, "R9 before last", 64'(req_ready), 64'd0);
    expect_done("R4 first", 4'd8, {PP_2, 12'h000});
    chk(req_ready == 1'b0, "R9 not same edge", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 freed later", 64'(req_ready), 64'd1);
    for (int i = 1; i < GROUPS; i++) begin
      respond(PG_A, PP_2);
      expect_done("R4 single", ID_W'(8 + i), {PP_2, 12'(i * 16)});
      chk(done_valid == 1'b0, "R4 one completion", 64'(done_valid), 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule